// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a synchronous host port to an asynchronous static RAM that is 16 bits wide, has a 20-bit word address and a separate strobe for each byte lane. The host pulses a request with a direction bit, an address, write data and a two-bit lane mask. The controller then drives the memory's address, its two chip selects, output enable, write enable and the two lane strobes. It controls the direction of the shared data bus and answers every accepted request with a one-cycle completion pulse. A read also returns its data with that pulse.

Every strobe and the data-bus enable come straight from flip-flops. The access length and the bus turnaround gap are set in nanoseconds and converted to clock cycles at elaboration by rounding up. The default clock period is 20 ns. When no access is running, the memory is held deselected and every strobe is held inactive. A write that arrives right after a read waits until the memory has had time to release the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset, and whenever no access is running, chip-select-1, write enable, output enable and both lane strobes are high (inactive), and the data-bus enable and the completion pulse are low.
- R2: A read drives chip-select-1 low, output enable low and write enable high. Lower strobe = NOT mask bit 0 (data bits 7:0), upper strobe = NOT mask bit 1 (data bits 15:8). These levels hold for exactly ceil(max(read cycle, address access, output-enable access)/clock) cycles, which is 4 at the defaults.
- R3: Read data is sampled from the bus on the last clock edge of the read and returned with the completion pulse. A lane whose mask bit is 0 returns 0.
- R4: A write holds chip-select-1 and write enable low for exactly ceil(max(write cycle, write pulse, address-to-end, data setup)/clock) cycles, which is 4 at the defaults. Output enable stays high for the whole write, and the data bus is driven only while write enable is low.
- R5: Address and write data stay unchanged for as long as chip-select-1 is low. Write enable and chip-select-1 rise on the same edge that releases the data bus.
- R6: After a read releases its strobes, the data-bus enable stays low for at least ceil(bus-release time/clock) cycles, which is 2 at the defaults. A write requested during that gap is delayed, not lost.
- R7: Each accepted request produces exactly one completion pulse, one cycle long.
- R8: A request raised while an access is running or waiting is ignored. It produces no completion pulse and does not change memory contents.
- R9: Chip-select-2 is low while reset is asserted and high from the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | One-cycle request pulse, sampled when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done after a read |
| mem_addr | output | 20 | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data-bus driver enable |
| mem_dq_in | input | 16 | Data returned from the memory |

## Verification
Two things can fall in the same cycle: the end of a read, which starts the bus-release gap, and the arrival of a write that wants to drive the bus. The bench provokes this by issuing a write in the first cycle it sees a read's completion pulse. A memory model with 1 ns resolution flags any nanosecond in which the controller's drivers are on while the memory drives the bus or is still releasing it. The scoreboard then checks that the delayed write still lands, and that it lands exactly once.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int ADDR_W = 20;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } ctrl_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } host_req_t;

    typedef struct packed {
        logic              cs1_n;
        logic              cs2;
        logic              oe_n;
        logic              we_n;
        logic [LANES-1:0]  be_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dq_out;
        logic              dq_oe;
    } pin_bus_t;

    // whole clock cycles covering a nanosecond minimum (rounded up, at least one)
    function automatic int cycles_for(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= value;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap
    import sram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[i*LANE_W +: LANE_W] <= '0;
            end else if (cap_en) begin
                rdata[i*LANE_W +: LANE_W] <= mask[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
            end
        end

        // R3: a lane left out of the mask comes back as zero
        assert_masked_lane_zero_R3: assert property (@(posedge clk) disable iff (rst)
            (cap_en && !mask[i]) |=> (rdata[i*LANE_W +: LANE_W] == '0));
    end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC = 4,
    parameter int WR_CYC = 4,
    parameter int TA_CYC = 2,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  host_req_t        req_i,
    input  logic             acc_zero,
    input  logic             gap_zero,
    output logic             acc_load,
    output logic [CNT_W-1:0] acc_val,
    output logic             gap_load,
    output logic [CNT_W-1:0] gap_val,
    output logic             cap_en,
    output logic [LANES-1:0] cap_mask,
    output logic             done,
    output pin_bus_t         pins
);

    localparam int GAP_W = $clog2(TA_CYC + 2);

    ctrl_state_e state;
    host_req_t   cur;
    host_req_t   src;
    logic        start_rd;
    logic        start_wr;
    logic        finish;

    always_comb begin
        src      = (state == ST_IDLE) ? req_i : cur;
        start_rd = (state == ST_IDLE) && req && !req_i.we;
        start_wr = ((state == ST_IDLE) && req && req_i.we && gap_zero) ||
                   ((state == ST_GAP) && gap_zero);
        finish   = ((state == ST_READ) || (state == ST_WRITE)) && acc_zero;
        acc_load = start_rd || start_wr;
        acc_val  = start_rd ? CNT_W'(RD_CYC - 1) : CNT_W'(WR_CYC - 1);
        gap_load = finish && (state == ST_READ);
        gap_val  = CNT_W'(TA_CYC - 1);
        cap_en   = finish && (state == ST_READ);
        cap_mask = cur.mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cur         <= '0;
            done        <= 1'b0;
            pins        <= '0;
            pins.cs1_n  <= 1'b1;
            pins.oe_n   <= 1'b1;
            pins.we_n   <= 1'b1;
            pins.be_n   <= '1;
        end else begin
            done     <= finish;
            pins.cs2 <= 1'b1;
            if (start_rd) begin
                state       <= ST_READ;
                cur         <= src;
                pins.cs1_n  <= 1'b0;
                pins.oe_n   <= 1'b0;
                pins.we_n   <= 1'b1;
                pins.be_n   <= ~src.mask;
                pins.addr   <= src.addr;
                pins.dq_oe  <= 1'b0;
            end else if (start_wr) begin
                state       <= ST_WRITE;
                cur         <= src;
                pins.cs1_n  <= 1'b0;
                pins.oe_n   <= 1'b1;
                pins.we_n   <= 1'b0;
                pins.be_n   <= ~src.mask;
                pins.addr   <= src.addr;
                pins.dq_out <= src.wdata;
                pins.dq_oe  <= 1'b1;
            end else if (finish) begin
                state       <= ST_IDLE;
                pins.cs1_n  <= 1'b1;
                pins.oe_n   <= 1'b1;
                pins.we_n   <= 1'b1;
                pins.be_n   <= '1;
                pins.dq_oe  <= 1'b0;
            end else if ((state == ST_IDLE) && req) begin
                // write held back by the bus-release gap
                state <= ST_GAP;
                cur   <= req_i;
            end
        end
    end

    // cycles since output enable was last low, saturating; checker state only
    logic [GAP_W-1:0] since_rd;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_rd <= GAP_W'(TA_CYC);
        end else if (!pins.oe_n) begin
            since_rd <= '0;
        end else if (since_rd < GAP_W'(TA_CYC)) begin
            since_rd <= since_rd + 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        pins.cs1_n |-> (pins.we_n && pins.oe_n && (&pins.be_n) && !pins.dq_oe));

    assert_no_oe_in_write_R4: assert property (@(posedge clk) disable iff (rst)
        !pins.we_n |-> pins.oe_n);

    assert_drive_in_write_R4: assert property (@(posedge clk) disable iff (rst)
        pins.dq_oe |-> (!pins.we_n && !pins.cs1_n));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!pins.cs1_n && $past(!pins.cs1_n)) |-> ($stable(pins.addr) && $stable(pins.dq_out)));

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.dq_oe) |-> (since_rd >= GAP_W'(TA_CYC)));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS  = 20,
    parameter int T_RC_NS = 70,
    parameter int T_AA_NS = 70,
    parameter int T_OE_NS = 35,
    parameter int T_WC_NS = 70,
    parameter int T_WP_NS = 50,
    parameter int T_AW_NS = 60,
    parameter int T_DW_NS = 30,
    parameter int T_HZ_NS = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC = cycles_for(max_of(T_RC_NS, max_of(T_AA_NS, T_OE_NS)), CLK_NS);
    localparam int WR_CYC = cycles_for(max_of(max_of(T_WC_NS, T_WP_NS),
                                              max_of(T_AW_NS, T_DW_NS)), CLK_NS);
    localparam int TA_CYC = cycles_for(T_HZ_NS, CLK_NS);
    localparam int MAX_CYC = max_of(max_of(RD_CYC, WR_CYC), TA_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    host_req_t        req_i;
    pin_bus_t         pins;
    logic             acc_load, acc_zero, gap_load, gap_zero, cap_en;
    logic [CNT_W-1:0] acc_val, gap_val;
    logic [LANES-1:0] cap_mask;

    assign req_i = '{we: req_we, addr: req_addr, wdata: req_wdata, mask: req_mask};

    sram_ctrl_fsm #(
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_i    (req_i),
        .acc_zero (acc_zero),
        .gap_zero (gap_zero),
        .acc_load (acc_load),
        .acc_val  (acc_val),
        .gap_load (gap_load),
        .gap_val  (gap_val),
        .cap_en   (cap_en),
        .cap_mask (cap_mask),
        .done     (done),
        .pins     (pins)
    );

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_acc_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (acc_load),
        .value (acc_val),
        .zero  (acc_zero)
    );

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_gap_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (gap_load),
        .value (gap_val),
        .zero  (gap_zero)
    );

    sram_ctrl_rdcap u_rdcap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .mask   (cap_mask),
        .dq_in  (mem_dq_in),
        .rdata  (rdata)
    );

    assign mem_addr   = pins.addr;
    assign mem_cs1_n  = pins.cs1_n;
    assign mem_cs2    = pins.cs2;
    assign mem_oe_n   = pins.oe_n;
    assign mem_we_n   = pins.we_n;
    assign mem_lb_n   = pins.be_n[0];
    assign mem_ub_n   = pins.be_n[1];
    assign mem_dq_out = pins.dq_out;
    assign mem_dq_oe  = pins.dq_oe;

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

    localparam int RD_CYC = 4;   // ceil(70/20)
    localparam int WR_CYC = 4;   // ceil(70/20)

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        done;
    logic [15:0] rdata;
    logic [19:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hA55A;

    sram_async_ctrl u_sram_async_ctrl (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    always #10ns clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model, 1 ns steps ----------------
    logic [15:0] mem [int];
    int  ns_now = 0;
    int  t_rd = 0, t_rd_end = -1000, t_wr = 0;
    bit  prev_rd = 0, prev_wr = 0, clash = 0, unstable = 0;
    logic [19:0] prev_addr = '0, wa = '0;
    logic [15:0] wd = '0;
    logic [1:0]  wbe = '0;

    always begin
        #1ns;
        ns_now++;
        begin
            bit sel, rd_act, wr_act;
            logic [15:0] word;
            sel    = !mem_cs1_n && mem_cs2;
            rd_act = sel && mem_we_n && !mem_oe_n && (!mem_lb_n || !mem_ub_n);
            wr_act = sel && !mem_we_n;
            if (rd_act && (!prev_rd || mem_addr != prev_addr)) t_rd = ns_now;
            if (prev_rd && !rd_act) t_rd_end = ns_now;
            word = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
            mem_dq_in[7:0]  = (rd_act && !mem_lb_n && ns_now - t_rd >= 70) ? word[7:0]  : 8'h5A;
            mem_dq_in[15:8] = (rd_act && !mem_ub_n && ns_now - t_rd >= 70) ? word[15:8] : 8'hA5;
            if (mem_dq_oe && (rd_act || ns_now - t_rd_end < 25)) clash = 1;
            if (wr_act && !prev_wr) begin
                t_wr = ns_now; unstable = 0;
            end else if (wr_act && (mem_addr != wa || mem_dq_out != wd)) begin
                unstable = 1;
            end
            if (wr_act) begin
                wa = mem_addr; wd = mem_dq_out; wbe = ~{mem_ub_n, mem_lb_n};
            end
            if (prev_wr && !wr_act) begin
                logic [15:0] old;
                old = mem.exists(int'(wa)) ? mem[int'(wa)] : 16'h0000;
                if (wbe[0]) old[7:0]  = wd[7:0];
                if (wbe[1]) old[15:8] = wd[15:8];
                mem[int'(wa)] = old;
                check(ns_now - t_wr >= 50, "R4 write pulse ns", ns_now - t_wr, 50);
                check(!clash, "R6 bus contention", clash, 0);
                check(!unstable, "R5 addr/data moved in write", unstable, 0);
                clash = 0;
            end
            prev_rd = rd_act; prev_wr = wr_act; prev_addr = mem_addr;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { bit is_rd; logic [15:0] data; logic [1:0] mask; } exp_t;
    exp_t exp_q[$];
    logic [15:0] shadow [int];
    int  oe_run = 0, we_run = 0;
    bit  prev_done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_oe_n) begin
                oe_run++;
                if (oe_run == 1 && exp_q.size() > 0)
                    check({mem_ub_n, mem_lb_n} == ~exp_q[0].mask && mem_we_n,
                          "R2 read strobes", {mem_ub_n, mem_lb_n}, ~exp_q[0].mask);
            end else if (oe_run != 0) begin
                check(oe_run == RD_CYC, "R2 read length", oe_run, RD_CYC);
                oe_run = 0;
            end
            if (!mem_we_n) begin
                we_run++;
                if (we_run == 1) check(mem_oe_n && mem_dq_oe, "R4 oe high, bus driven", mem_oe_n, 1);
            end else if (we_run != 0) begin
                check(we_run == WR_CYC && !mem_dq_oe, "R4 write length", we_run, WR_CYC);
                we_run = 0;
            end
            if (done) begin
                check(!prev_done, "R7 done longer than one cycle", prev_done, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R7/R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.is_rd) check(rdata == e.data, "R3 read data", rdata, e.data);
                    else         check(1, "R7 write done", 1, 1);
                end
            end
            prev_done = done;
        end
    end

    function automatic logic [15:0] lane_mask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic do_req(input bit we, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] m, input bit check_idle);
        exp_t e;
        logic [15:0] cur;
        cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        e.is_rd = !we; e.mask = m;
        e.data  = we ? 16'h0 : (cur & lane_mask(m));
        if (we) shadow[int'(a)] = (cur & ~lane_mask(m)) | (d & lane_mask(m));
        exp_q.push_back(e);
        req = 1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req = 0;
        while (exp_q.size() != 0) @(negedge clk);
        if (check_idle) begin
            @(negedge clk);
            check(mem_cs1_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !done,
                  "R1 idle pins", {mem_cs1_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mem_cs1_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !done,
              "R1 reset pins", {mem_cs1_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
        check(mem_cs2 == 1'b0, "R9 cs2 in reset", mem_cs2, 0);
        rst = 0;
        @(negedge clk);
        check(mem_cs2 == 1'b1, "R9 cs2 after reset", mem_cs2, 1);

        do_req(1, 20'h00012, 16'h1234, 2'b11, 1);
        do_req(0, 20'h00012, 16'h0,    2'b11, 1);
        do_req(0, 20'h00012, 16'h0,    2'b01, 1);   // R3 lower lane only
        do_req(0, 20'h00012, 16'h0,    2'b10, 1);   // R3 upper lane only
        do_req(1, 20'h00012, 16'hABCD, 2'b01, 1);
        do_req(0, 20'h00012, 16'h0,    2'b11, 1);
        do_req(1, 20'h00012, 16'h77EE, 2'b10, 1);
        do_req(0, 20'h00012, 16'h0,    2'b11, 1);
        do_req(1, 20'hFFFFF, 16'hBEEF, 2'b11, 1);
        do_req(0, 20'hFFFFF, 16'h0,    2'b00, 1);   // R3 no lanes -> zero
        do_req(1, 20'hFFFFF, 16'h0000, 2'b00, 1);   // no lanes written
        do_req(0, 20'hFFFFF, 16'h0,    2'b11, 1);

        // R6: write issued in the cycle the read completes
        for (int i = 0; i < 8; i++) begin
            do_req(0, 20'hFFFFF, 16'h0, 2'b11, 0);
            do_req(1, 20'(32'h100 + i * 32'h1111), 16'(32'h3C00 + i * 32'h0107), 2'b11, 0);
            do_req(0, 20'(32'h100 + i * 32'h1111), 16'h0, 2'(i % 3 + 1), 0);
        end

        // R8: request while busy is ignored
        begin
            exp_t e;
            e.is_rd = 1; e.mask = 2'b11; e.data = shadow[int'(20'h00012)];
            exp_q.push_back(e);
            req = 1; req_we = 0; req_addr = 20'h00012; req_mask = 2'b11;
            @(negedge clk);
            req = 0;
            @(negedge clk);
            req = 1; req_we = 1; req_addr = 20'h00012; req_wdata = 16'hDEAD; req_mask = 2'b11;
            @(negedge clk);
            req = 0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (8) @(negedge clk);
        end
        do_req(0, 20'h00012, 16'h0, 2'b11, 1);   // R8 memory unchanged

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(0, "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule